// File: doc/BRIEF.md
# Serial Stereo Audio Transmitter

This block turns a stream of 16-bit stereo sample pairs into three serial lines: a bit clock, a left/right word clock and a data line. All three are derived from a single master clock that runs at 384 times the sample rate. A frame (one sample period) therefore always lasts 384 master cycles. Each frame carries 32, 48 or 64 bit periods, depending on the slot mode. At the usual 44.1 kHz sample rate, the 32-bit mode produces a 1.4112 MHz bit clock.

A producer offers sample pairs through a valid/ready handshake. Ready pulses once per frame, in the last master cycle, and the offered pair is used for the following frame. Slot mode, word clock polarity and bit order are sampled at the same instant, so a frame is never transmitted with mixed settings. If no pair is offered when ready pulses, the next frame carries silence and a sticky underrun flag is raised.

Top module: `stereo_serial_tx`

## Requirements
- R1: A bit period spans 12, 8 or 6 master cycles for slot_mode 2'b00, 2'b01 and 2'b10 respectively, and 2'b11 behaves as 2'b00. bclk_o is low for the first half of each bit period and high for the second half. Every frame is 384 master cycles long.
- R2: With wclk_inv_i clear, wclk_o is low for bit periods 0 to S-1 of a frame (the left slot) and high for bit periods S to 2S-1 (the right slot), where S is 16, 24 or 32 bits per channel. Each channel's first data bit follows one bit period after the word clock edge for that channel.
- R3: With wclk_inv_i set, wclk_o is the complement of the R2 waveform.
- R4: The left sample bits occupy bit periods 1 to 16 and the right sample bits occupy bit periods S+1 to S+16. With lsb_first_i clear, bit 15 is sent first; with it set, bit 0 is sent first.
- R5: All other bit periods carry zero. The one exception is the 16-bit slot mode, where the final right bit is carried in bit period 0 of the next frame.
- R6: sdata_o and wclk_o change only in the master cycle in which bclk_o falls.
- R7: slot_mode, wclk_inv_i and lsb_first_i are sampled only in the last master cycle of a frame. After reset, the first frame uses mode 2'b00, no inversion and MSB first.
- R8: If s_valid_i is low when s_ready_o is high, the next frame sends zeros on both channels, and underrun_o rises and stays high until reset.
- R9: s_ready_o is high for exactly the last master cycle of each frame. The pair on s_left_i/s_right_i is taken in that cycle when s_valid_i is high.
- R10: During and just after reset, bclk_o, wclk_o, sdata_o, s_ready_o and underrun_o are low, and the first frame carries zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 384x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_mode | input | 2 | Bits per frame select: 00=32, 01=48, 10=64, 11=32 |
| wclk_inv_i | input | 1 | Invert word clock |
| lsb_first_i | input | 1 | Send each sample LSB first |
| s_valid_i | input | 1 | Sample pair offered |
| s_ready_o | output | 1 | Pair taken this cycle (frame end) |
| s_left_i | input | 16 | Left sample |
| s_right_i | input | 16 | Right sample |
| bclk_o | output | 1 | Serial bit clock |
| wclk_o | output | 1 | Left/right word clock |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky missing-sample flag |

## Verification
The bench targets several corner cases:
- The wrap of the 16-bit mode. A design that drops the carried final right bit would send zero in bit period 0 and lose the LSB (or MSB) of every right sample.
- Setting changes in the middle of a frame. A design that does not hold its settings until the frame boundary would switch its divider partway through the frame, and the frame would no longer be 384 cycles long.
- Both bit orders and word clock inversion in every slot mode. An indexing slip here shifts the data by one bit period relative to the word clock.
- A run of frames with no sample offered, followed by valid data again. This shows whether silence is inserted and whether the underrun flag stays set.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    SLOT_16 = 2'b00,
    SLOT_24 = 2'b01,
    SLOT_32 = 2'b10
  } slot_e;

  typedef struct packed {
    slot_e slot;
    logic  inv;
    logic  lsb;
  } cfg_t;

  function automatic slot_e norm_slot(input logic [1:0] raw);
    case (raw)
      2'b01:   return SLOT_24;
      2'b10:   return SLOT_32;
      default: return SLOT_16;
    endcase
  endfunction
endpackage

// File: rtl/stx_bit_timer.sv
module stx_bit_timer
  import stx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int MCLK_PER_FS = 384,
  parameter int DIV_W       = 4,
  parameter int BIT_W       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_e            slot,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             frame_end,
  output logic             bclk
);
  localparam int BITS16 = 2 * SAMPLE_W;
  localparam int BITS24 = 3 * SAMPLE_W;
  localparam int BITS32 = 4 * SAMPLE_W;
  localparam logic [DIV_W-1:0] DLAST16 = DIV_W'(MCLK_PER_FS / BITS16 - 1);
  localparam logic [DIV_W-1:0] DLAST24 = DIV_W'(MCLK_PER_FS / BITS24 - 1);
  localparam logic [DIV_W-1:0] DLAST32 = DIV_W'(MCLK_PER_FS / BITS32 - 1);
  localparam logic [DIV_W-1:0] HALF16  = DIV_W'(MCLK_PER_FS / BITS16 / 2);
  localparam logic [DIV_W-1:0] HALF24  = DIV_W'(MCLK_PER_FS / BITS24 / 2);
  localparam logic [DIV_W-1:0] HALF32  = DIV_W'(MCLK_PER_FS / BITS32 / 2);
  localparam logic [BIT_W-1:0] BLAST16 = BIT_W'(BITS16 - 1);
  localparam logic [BIT_W-1:0] BLAST24 = BIT_W'(BITS24 - 1);
  localparam logic [BIT_W-1:0] BLAST32 = BIT_W'(BITS32 - 1);

  logic [DIV_W-1:0] div_q, div_d, div_last, div_half;
  logic [BIT_W-1:0] bit_q, bit_d, bit_last;
  logic             period_end;

  always_comb begin
    case (slot)
      SLOT_24: begin div_last = DLAST24; div_half = HALF24; bit_last = BLAST24; end
      SLOT_32: begin div_last = DLAST32; div_half = HALF32; bit_last = BLAST32; end
      default: begin div_last = DLAST16; div_half = HALF16; bit_last = BLAST16; end
    endcase
  end

  assign period_end = (div_q == div_last);
  assign frame_end  = period_end && (bit_q == bit_last);

  always_comb begin
    div_d = div_q + 1'b1;
    bit_d = bit_q;
    if (period_end) begin
      div_d = '0;
      bit_d = frame_end ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      bit_q <= '0;
    end else begin
      div_q <= div_d;
      bit_q <= bit_d;
    end
  end

  assign bit_cnt = bit_q;
  assign bclk    = (div_q >= div_half);
endmodule

// File: rtl/stx_frame_loader.sv
module stx_frame_loader
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  cfg_t                cfg_in,
  input  logic                pair_valid,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output cfg_t                cfg_q,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                tail_q,
  output logic                underrun
);
  cfg_t                cfg_d;
  logic [SAMPLE_W-1:0] left_d, right_d;
  logic                tail_d, under_d, last_right_bit;

  // final right bit of the running frame, in transmit order
  assign last_right_bit = cfg_q.lsb ? right_q[SAMPLE_W-1] : right_q[0];

  always_comb begin
    cfg_d   = cfg_q;
    left_d  = left_q;
    right_d = right_q;
    tail_d  = tail_q;
    under_d = underrun;
    if (frame_end) begin
      cfg_d  = cfg_in;
      tail_d = (cfg_q.slot == SLOT_16) ? last_right_bit : 1'b0;
      if (pair_valid) begin
        left_d  = left_in;
        right_d = right_in;
      end else begin
        left_d  = '0;
        right_d = '0;
        under_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{slot: SLOT_16, inv: 1'b0, lsb: 1'b0};
      left_q   <= '0;
      right_q  <= '0;
      tail_q   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      left_q   <= left_d;
      right_q  <= right_d;
      tail_q   <= tail_d;
      underrun <= under_d;
    end
  end
endmodule

// File: rtl/stx_bit_select.sv
module stx_bit_select
  import stx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int BIT_W    = 6
) (
  input  cfg_t                cfg,
  input  logic [BIT_W-1:0]    bit_cnt,
  input  logic [SAMPLE_W-1:0] left_w,
  input  logic [SAMPLE_W-1:0] right_w,
  input  logic                tail,
  output logic                sdata,
  output logic                wclk
);
  localparam int IDX_W = $clog2(SAMPLE_W);
  localparam logic [BIT_W-1:0] W_B     = BIT_W'(SAMPLE_W);
  localparam logic [BIT_W-1:0] LEN16   = BIT_W'(SAMPLE_W);
  localparam logic [BIT_W-1:0] LEN24   = BIT_W'(3 * SAMPLE_W / 2);
  localparam logic [BIT_W-1:0] LEN32   = BIT_W'(2 * SAMPLE_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(SAMPLE_W - 1);

  logic [BIT_W-1:0] slot_len, pos;
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (cfg.slot)
      SLOT_24: slot_len = LEN24;
      SLOT_32: slot_len = LEN32;
      default: slot_len = LEN16;
    endcase
  end

  assign wclk = (bit_cnt >= slot_len) ^ cfg.inv;

  always_comb begin
    sdata = 1'b0;
    pos   = '0;
    idx   = '0;
    if (bit_cnt == '0) begin
      sdata = tail;
    end else if (bit_cnt <= W_B) begin
      pos   = bit_cnt - 1'b1;
      idx   = cfg.lsb ? pos[IDX_W-1:0] : TOP_IDX - pos[IDX_W-1:0];
      sdata = left_w[idx];
    end else if ((bit_cnt > slot_len) && (bit_cnt <= slot_len + W_B)) begin
      pos   = bit_cnt - slot_len - 1'b1;
      idx   = cfg.lsb ? pos[IDX_W-1:0] : TOP_IDX - pos[IDX_W-1:0];
      sdata = right_w[idx];
    end
  end
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import stx_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int MCLK_PER_FS = 384
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          slot_mode,
  input  logic                wclk_inv_i,
  input  logic                lsb_first_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  input  logic [SAMPLE_W-1:0] s_left_i,
  input  logic [SAMPLE_W-1:0] s_right_i,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                sdata_o,
  output logic                underrun_o
);
  localparam int DIV_W = $clog2(MCLK_PER_FS / (2 * SAMPLE_W));
  localparam int BIT_W = $clog2(4 * SAMPLE_W);

  cfg_t                cfg_in, cfg_q;
  logic [BIT_W-1:0]    bit_cnt;
  logic                frame_end, tail_q;
  logic [SAMPLE_W-1:0] left_q, right_q;

  assign cfg_in = '{slot: norm_slot(slot_mode), inv: wclk_inv_i, lsb: lsb_first_i};

  stx_bit_timer #(
    .SAMPLE_W(SAMPLE_W), .MCLK_PER_FS(MCLK_PER_FS), .DIV_W(DIV_W), .BIT_W(BIT_W)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .slot(cfg_q.slot),
    .bit_cnt(bit_cnt), .frame_end(frame_end), .bclk(bclk_o)
  );

  stx_frame_loader #(.SAMPLE_W(SAMPLE_W)) loader_i (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cfg_in(cfg_in),
    .pair_valid(s_valid_i), .left_in(s_left_i), .right_in(s_right_i),
    .cfg_q(cfg_q), .left_q(left_q), .right_q(right_q), .tail_q(tail_q),
    .underrun(underrun_o)
  );

  stx_bit_select #(.SAMPLE_W(SAMPLE_W), .BIT_W(BIT_W)) select_i (
    .cfg(cfg_q), .bit_cnt(bit_cnt), .left_w(left_q), .right_w(right_q),
    .tail(tail_q), .sdata(sdata_o), .wclk(wclk_o)
  );

  assign s_ready_o = frame_end;
endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid_i,
  input logic s_ready_o,
  input logic bclk_o,
  input logic wclk_o,
  input logic sdata_o,
  input logic underrun_o
);
  // R6
  sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> $fell(bclk_o));

  // R6
  wclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wclk_o) |-> $fell(bclk_o));

  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

  // R8
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready_o && !s_valid_i) |=> underrun_o);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |=> !s_ready_o);

  // R9
  ready_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |=> $fell(bclk_o));
endmodule

bind stereo_serial_tx stereo_serial_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o), .underrun_o(underrun_o)
);

// File: tb/stereo_serial_tx_tb_top.sv
module stereo_serial_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot_mode = 2'b00;
  logic        wclk_inv_i = 1'b0, lsb_first_i = 1'b0, s_valid_i = 1'b0;
  logic [15:0] s_left_i = '0, s_right_i = '0;
  logic        s_ready_o, bclk_o, wclk_o, sdata_o, underrun_o;

  always #5 clk = ~clk;

  stereo_serial_tx dut_i (
    .clk(clk), .rst_n(rst_n), .slot_mode(slot_mode), .wclk_inv_i(wclk_inv_i),
    .lsb_first_i(lsb_first_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .s_left_i(s_left_i), .s_right_i(s_right_i), .bclk_o(bclk_o),
    .wclk_o(wclk_o), .sdata_o(sdata_o), .underrun_o(underrun_o)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int       pos = 0;
  int       m_slot = 0;
  bit       m_inv = 0, m_lsb = 0, m_tail = 0, m_under = 0;
  bit [15:0] m_l = '0, m_r = '0;
  bit       took = 0;
  bit       prev_bclk = 0, prev_sdata = 0, prev_wclk = 0;

  function automatic int chan_bits(int s);
    return (s == 1) ? 24 : ((s == 2) ? 32 : 16);
  endfunction

  function automatic int norm(logic [1:0] m);
    return (m == 2'b01) ? 1 : ((m == 2'b10) ? 2 : 0);
  endfunction

  function automatic bit pick(bit [15:0] w, int j, bit lsb);
    return lsb ? w[j] : w[15 - j];
  endfunction

  task automatic check1(string tag, logic act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (frame pos %0d)", tag, what, act, exp, pos);
    end
  endtask

  task automatic compare();
    int  s, d, k, ph;
    bit  e_bclk, e_wclk, e_data, pad;
    string cfg_tag;
    s  = chan_bits(m_slot);
    d  = 384 / (2 * s);
    k  = pos / d;
    ph = pos % d;
    e_bclk = (ph >= d / 2);
    e_wclk = (k >= s) ^ m_inv;
    pad = 1'b0;
    if (k == 0)                                e_data = m_tail;
    else if (k <= 16)                          e_data = pick(m_l, k - 1, m_lsb);
    else if (k > s && k <= s + 16 && k < 2*s)  e_data = pick(m_r, k - s - 1, m_lsb);
    else begin e_data = 1'b0; pad = 1'b1; end
    cfg_tag = (norm(slot_mode) != m_slot || wclk_inv_i != m_inv || lsb_first_i != m_lsb)
              ? "R7" : "";
    check1(cfg_tag != "" ? "R7" : "R1", bclk_o, e_bclk, "bclk");
    check1(cfg_tag != "" ? "R7" : (m_inv ? "R3" : "R2"), wclk_o, e_wclk, "wclk");
    check1(cfg_tag != "" ? "R7" : (pad ? "R5" : "R4"), sdata_o, e_data, "sdata");
    check1("R9", s_ready_o, (pos == 383), "s_ready");
    check1("R8", underrun_o, m_under, "underrun");
    if (sdata_o !== prev_sdata || wclk_o !== prev_wclk)
      check1("R6", prev_bclk && !bclk_o, 1'b1, "change away from bclk fall");
    prev_bclk  = bclk_o;
    prev_sdata = sdata_o;
    prev_wclk  = wclk_o;
  endtask

  task automatic tick();
    @(posedge clk);
    took = 0;
    if (pos == 383) begin
      m_tail = (m_slot == 0) ? pick(m_r, 15, m_lsb) : 1'b0;
      m_slot = norm(slot_mode);
      m_inv  = wclk_inv_i;
      m_lsb  = lsb_first_i;
      if (s_valid_i) begin
        m_l = s_left_i; m_r = s_right_i; took = 1;
      end else begin
        m_l = '0; m_r = '0; m_under = 1;
      end
      pos = 0;
    end else begin
      pos++;
    end
    @(negedge clk);
    compare();
    if (took) begin
      s_left_i  = 16'($urandom);
      s_right_i = 16'($urandom);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    s_left_i  = 16'h8001;
    s_right_i = 16'hC003;
    s_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    check1("R10", bclk_o, 1'b0, "bclk in reset");
    check1("R10", wclk_o, 1'b0, "wclk in reset");
    check1("R10", sdata_o, 1'b0, "sdata in reset");
    check1("R10", s_ready_o, 1'b0, "s_ready in reset");
    check1("R10", underrun_o, 1'b0, "underrun in reset");
    rst_n = 1'b1;
    compare();
    run(383);                          // R10: first frame zero samples
    run(384 * 3);                      // 32x, MSB first
    slot_mode = 2'b01;  run(384 * 2);  // 48x
    slot_mode = 2'b10; lsb_first_i = 1'b1; run(384 * 2);  // 64x LSB first
    slot_mode = 2'b00; run(384 * 2);   // 32x LSB first: tail bit
    wclk_inv_i = 1'b1; slot_mode = 2'b01; run(384 * 2);   // R3
    run(100);                          // R7: mid-frame change
    slot_mode = 2'b11; wclk_inv_i = 1'b0; lsb_first_i = 1'b0;
    run(284 + 384 * 2);
    s_valid_i = 1'b0; run(384 * 2);    // R8: underrun
    s_valid_i = 1'b1; slot_mode = 2'b10; run(384 * 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule